// File: doc/BRIEF.md
# SPI Flash Menu-Driven Command Sequencer

This block issues single SPI flash commands under register control. Software loads a menu of eight opcodes, each with a 2-bit type. It also loads two prefix opcodes, the flash address and up to 64 bytes in a shared data buffer. It then writes the control/status word with the go bit and a menu index. The engine frames the chosen opcode on the serial pins. An address phase follows if the entry's type carries one, and a data phase if data is enabled. Read data lands in the buffer and write data is taken from it.

For write-type entries, an atomic sequence can be requested, for example write-enable ahead of a program or erase. The engine then sends one of the two prefix opcodes in its own chip-select frame. It releases chip select for a cycle and sends the main command. Busy, done and two error flags report progress through the same control/status word. The register port is a plain synchronous write / combinational read interface with no back-pressure, because every access completes in one cycle.

Top module: `spi_menu_sequencer`

## Requirements
- R1: After reset the control/status word (register 0) reads zero, chip select is high and the serial clock is low.
- R2: Writing register 0 with go (bit 9) sends the opcode of menu entry index (bits 14:12) as the first byte of the main frame. Entries 0-3 are the bytes of register 2 and entries 4-7 the bytes of register 3, with the lowest index in the lowest byte.
- R3: An entry's type lies in register 4 at bits 16+2i+1:16+2i, where i is the entry index. Type 0 is read without address, 1 write without address, 2 read with address and 3 write with address. Types 2 and 3 follow the opcode with three address bytes from register 1, most significant first. Types 0 and 1 send no address.
- R4: A write-type entry with data enabled (bit 22) sends count+1 bytes from the buffer, where count is bits 21:16. Buffer byte n sits in register 16+n/4 at bits 8*(n%4)+7:8*(n%4), and the full 64 bytes can be sent.
- R5: A read-type entry with data enabled stores count+1 received bytes into the buffer in that same byte layout.
- R6: With data disabled no data bytes move, whatever the count field holds.
- R7: With bit 10 set on a write-type entry, a separate one-byte frame carries prefix 0 (register 4 bits 7:0) or, with bit 11 set, prefix 1 (bits 15:8). Chip select then goes high before the main frame.
- R8: Bit 10 set on a read-type entry sets access error (bit 4), starts no frame and leaves busy clear.
- R9: Busy (bit 0) reads 1 from the cycle after go until the last frame ends. Done (bit 2) is set when busy clears, and chip select is then high.
- R10: Go written while busy sets cycle error (bit 3). The running command and the stored fields are left unchanged.
- R11: Done, cycle error and access error clear when written with 1 and are kept when written with 0.
- R12: The serial clock idles low. Bytes go out most significant bit first, MOSI stays steady across the rising clock edge, and MISO is sampled while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Word address: 0-4 control registers, 16-31 data buffer |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at bus_addr |
| spi_sck | output | 1 | Serial clock, half the core rate |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A go write takes effect on the clock edge that ends the write cycle, so busy, access error and cycle error can be read in the very next cycle. The bench reads them there. Done and the received buffer bytes are valid from the cycle in which busy reads 0. The bench therefore polls busy and reads results and frames only after it has dropped. A flash model samples the serial pins midway between core edges and records every chip-select frame. This lets the expected byte sequences be compared after each command, without timing assumptions inside a frame.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;
  // control/status word bit positions
  localparam int unsigned CSW_BUSY = 0;
  localparam int unsigned CSW_DONE = 2;
  localparam int unsigned CSW_CERR = 3;
  localparam int unsigned CSW_AERR = 4;
  localparam int unsigned CSW_GO   = 9;
  localparam int unsigned CSW_ATOM = 10;
  localparam int unsigned CSW_PSEL = 11;
  localparam int unsigned CSW_IDX  = 12;
  localparam int unsigned CSW_CNT  = 16;
  localparam int unsigned CSW_DEN  = 22;

  // control register word indices
  localparam int unsigned RA_CSW     = 0;
  localparam int unsigned RA_FADDR   = 1;
  localparam int unsigned RA_MENU_LO = 2;
  localparam int unsigned RA_MENU_HI = 3;
  localparam int unsigned RA_PRETYPE = 4;

  localparam int unsigned MENU_N = 8;
  localparam int unsigned IDX_W  = $clog2(MENU_N);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP, ST_CMD, ST_ADR, ST_DAT, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int unsigned BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic          active_q, ph_q, done_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !active_q) begin
        active_q <= 1'b1;
        ph_q     <= 1'b0;
        bit_q    <= '0;
        sr_q     <= tx;
      end else if (active_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q  <= 1'b0;
          sr_q  <= {sr_q[W-2:0], miso};
          bit_q <= bit_q + 1'b1;
          if (bit_q == LAST) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign sck  = active_q & ph_q;
  assign mosi = sr_q[W-1];
  assign done = done_q;
  assign rx   = sr_q;

  // R12: data line does not move across the rising serial clock edge
  a_r12_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine
  import spi_menu_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned BUF_BYTES  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [7:0]            i_opc,
  input  logic [7:0]            i_pre,
  input  logic [1:0]            i_typ,
  input  logic                  i_atomic,
  input  logic                  i_den,
  input  logic [$clog2(BUF_BYTES)-1:0] i_cnt,
  input  logic [8*ADDR_BYTES-1:0] i_addr,
  input  logic [7:0]            rd_byte,
  output logic [$clog2(BUF_BYTES)-1:0] rd_idx,
  output logic                  buf_we,
  output logic [$clog2(BUF_BYTES)-1:0] buf_widx,
  output logic [7:0]            buf_wdat,
  output logic                  busy,
  output logic                  done_evt,
  output logic                  cs_n,
  output logic                  sh_start,
  output logic [7:0]            sh_tx,
  input  logic                  sh_done,
  input  logic [7:0]            sh_rx
);
  localparam int unsigned CW = $clog2(BUF_BYTES);
  localparam int unsigned AW = 8 * ADDR_BYTES;
  localparam int unsigned KW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [KW-1:0] LASTK = KW'(ADDR_BYTES - 1);

  seq_state_e    st_q;
  logic          busy_q, inflight_q, sh_start_q, we_q;
  logic [7:0]    opc_q, pre_q, sh_tx_q, wdat_q;
  logic [1:0]    typ_q;
  logic          den_q;
  logic [CW-1:0] cnt_q, n_q, widx_q;
  logic [AW-1:0] adr_q;
  logic [KW-1:0] k_q;
  logic [7:0]    tx_sel;

  always_comb begin
    case (st_q)
      ST_PRE:  tx_sel = pre_q;
      ST_CMD:  tx_sel = opc_q;
      ST_ADR:  tx_sel = adr_q[AW-1 -: 8];
      ST_DAT:  tx_sel = typ_q[0] ? rd_byte : 8'h00;
      default: tx_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  busy_q <= 1'b0; inflight_q <= 1'b0;
      sh_start_q <= 1'b0; sh_tx_q <= '0; we_q <= 1'b0;
      widx_q <= '0; wdat_q <= '0; k_q <= '0; n_q <= '0;
      opc_q <= '0; pre_q <= '0; typ_q <= '0; den_q <= 1'b0;
      cnt_q <= '0; adr_q <= '0;
    end else begin
      sh_start_q <= 1'b0;
      we_q       <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          opc_q <= i_opc;  pre_q <= i_pre;  typ_q <= i_typ;
          den_q <= i_den;  cnt_q <= i_cnt;  adr_q <= i_addr;
          busy_q <= 1'b1;  inflight_q <= 1'b0;
          k_q <= '0;       n_q <= '0;
          st_q <= i_atomic ? ST_PRE : ST_CMD;
        end
        ST_GAP: st_q <= ST_CMD;
        ST_FIN: begin
          busy_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: begin
          if (!inflight_q) begin
            sh_start_q <= 1'b1;
            sh_tx_q    <= tx_sel;
            inflight_q <= 1'b1;
          end else if (sh_done) begin
            inflight_q <= 1'b0;
            case (st_q)
              ST_PRE: st_q <= ST_GAP;
              ST_CMD: st_q <= typ_q[1] ? ST_ADR : (den_q ? ST_DAT : ST_FIN);
              ST_ADR: begin
                adr_q <= adr_q << 8;
                if (k_q == LASTK) st_q <= den_q ? ST_DAT : ST_FIN;
                else              k_q  <= k_q + 1'b1;
              end
              ST_DAT: begin
                if (!typ_q[0]) begin
                  we_q   <= 1'b1;
                  widx_q <= n_q;
                  wdat_q <= sh_rx;
                end
                if (n_q == cnt_q) st_q <= ST_FIN;
                else              n_q  <= n_q + 1'b1;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign cs_n     = !(st_q inside {ST_PRE, ST_CMD, ST_ADR, ST_DAT});
  assign busy     = busy_q;
  assign done_evt = (st_q == ST_FIN);
  assign sh_start = sh_start_q;
  assign sh_tx    = sh_tx_q;
  assign rd_idx   = n_q;
  assign buf_we   = we_q;
  assign buf_widx = widx_q;
  assign buf_wdat = wdat_q;

  // R9: chip select never active outside a command
  a_r9_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> cs_n);
  // R4: data beat index stays within the programmed count
  a_r4_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAT) |-> (n_q <= cnt_q));
endmodule

// File: rtl/spi_menu_sequencer.sv
module spi_menu_sequencer
  import spi_menu_pkg::*;
#(
  parameter int unsigned BUF_BYTES  = 64,
  parameter int unsigned ADDR_BYTES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [$clog2(BUF_BYTES/4):0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int unsigned WIN_AW = $clog2(BUF_BYTES / 4);
  localparam int unsigned RAW    = WIN_AW + 1;
  localparam int unsigned CW     = $clog2(BUF_BYTES);
  localparam int unsigned AW     = 8 * ADDR_BYTES;

  logic [AW-1:0]    faddr_q;
  logic [8*MENU_N-1:0] menu_q;
  logic [31:0]      pretype_q;
  logic [7:0]       buf_q [BUF_BYTES];
  logic             atom_q, psel_q, den_q, done_q, cerr_q, aerr_q;
  logic [IDX_W-1:0] idx_q;
  logic [CW-1:0]    cnt_q;

  logic             eng_busy, done_evt, eng_we, sh_start, sh_done;
  logic [CW-1:0]    eng_ridx, eng_widx;
  logic [7:0]       eng_wdat, sh_tx, sh_rx;

  logic             is_win, csw_wr, go_req, w_atom, start;
  logic [IDX_W-1:0] w_idx;
  logic [1:0]       w_typ;
  logic [WIN_AW-1:0] reg_sel;

  assign is_win  = bus_addr[RAW-1];
  assign reg_sel = bus_addr[WIN_AW-1:0];
  assign csw_wr  = bus_we && !is_win && (reg_sel == WIN_AW'(RA_CSW));
  assign w_idx   = bus_wdata[CSW_IDX +: IDX_W];
  assign w_atom  = bus_wdata[CSW_ATOM];
  assign w_typ   = pretype_q[16 + 2*w_idx +: 2];
  assign go_req  = csw_wr && bus_wdata[CSW_GO];
  assign start   = go_req && !eng_busy && !(w_atom && !w_typ[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0; menu_q <= '0; pretype_q <= '0;
      atom_q <= 1'b0; psel_q <= 1'b0; den_q <= 1'b0;
      idx_q <= '0; cnt_q <= '0;
      done_q <= 1'b0; cerr_q <= 1'b0; aerr_q <= 1'b0;
    end else begin
      if (bus_we && !is_win) begin
        case (int'(reg_sel))
          RA_CSW: begin
            if (!eng_busy) begin
              atom_q <= bus_wdata[CSW_ATOM];
              psel_q <= bus_wdata[CSW_PSEL];
              idx_q  <= w_idx;
              cnt_q  <= bus_wdata[CSW_CNT +: CW];
              den_q  <= bus_wdata[CSW_DEN];
            end
            if (bus_wdata[CSW_DONE]) done_q <= 1'b0;
            if (bus_wdata[CSW_CERR]) cerr_q <= 1'b0;
            if (bus_wdata[CSW_AERR]) aerr_q <= 1'b0;
          end
          RA_FADDR:   faddr_q           <= bus_wdata[AW-1:0];
          RA_MENU_LO: menu_q[31:0]      <= bus_wdata;
          RA_MENU_HI: menu_q[63:32]     <= bus_wdata;
          RA_PRETYPE: pretype_q         <= bus_wdata;
          default: ;
        endcase
      end
      if (done_evt)                                    done_q <= 1'b1;
      if (go_req && eng_busy)                          cerr_q <= 1'b1;
      if (go_req && !eng_busy && w_atom && !w_typ[0])  aerr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_we && is_win)
      for (int j = 0; j < 4; j++)
        buf_q[{reg_sel, 2'(j)}] <= bus_wdata[8*j +: 8];
    if (eng_we) buf_q[eng_widx] <= eng_wdat;
  end

  always_comb begin
    bus_rdata = '0;
    if (is_win) begin
      for (int j = 0; j < 4; j++)
        bus_rdata[8*j +: 8] = buf_q[{reg_sel, 2'(j)}];
    end else begin
      case (int'(reg_sel))
        RA_CSW: begin
          bus_rdata[CSW_BUSY]         = eng_busy;
          bus_rdata[CSW_DONE]         = done_q;
          bus_rdata[CSW_CERR]         = cerr_q;
          bus_rdata[CSW_AERR]         = aerr_q;
          bus_rdata[CSW_ATOM]         = atom_q;
          bus_rdata[CSW_PSEL]         = psel_q;
          bus_rdata[CSW_IDX +: IDX_W] = idx_q;
          bus_rdata[CSW_CNT +: CW]    = cnt_q;
          bus_rdata[CSW_DEN]          = den_q;
        end
        RA_FADDR:   bus_rdata[AW-1:0] = faddr_q;
        RA_MENU_LO: bus_rdata = menu_q[31:0];
        RA_MENU_HI: bus_rdata = menu_q[63:32];
        RA_PRETYPE: bus_rdata = pretype_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  spi_menu_engine #(.ADDR_BYTES(ADDR_BYTES), .BUF_BYTES(BUF_BYTES)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .i_opc    (menu_q[8*w_idx +: 8]),
    .i_pre    (bus_wdata[CSW_PSEL] ? pretype_q[15:8] : pretype_q[7:0]),
    .i_typ    (w_typ),
    .i_atomic (w_atom),
    .i_den    (bus_wdata[CSW_DEN]),
    .i_cnt    (bus_wdata[CSW_CNT +: CW]),
    .i_addr   (faddr_q),
    .rd_byte  (buf_q[eng_ridx]),
    .rd_idx   (eng_ridx),
    .buf_we   (eng_we),
    .buf_widx (eng_widx),
    .buf_wdat (eng_wdat),
    .busy     (eng_busy),
    .done_evt (done_evt),
    .cs_n     (spi_cs_n),
    .sh_start (sh_start),
    .sh_tx    (sh_tx),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx)
  );

  spi_byte_shifter #(.W(8)) u_shifter (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  // R9: done is raised at the moment busy drops
  a_r9_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> done_q);
  // R10: a second go during a command flags a cycle error
  a_r10_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && eng_busy) |=> cerr_q);
  // R8: atomic prefix on a read entry is refused
  a_r8_atomic_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !eng_busy && w_atom && !w_typ[0]) |=> (aerr_q && !eng_busy));
endmodule

// File: tb/spi_menu_sequencer_bench.sv
module spi_menu_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        miso_q = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_menu_sequencer u_spi_menu_sequencer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_q)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  // flash model: records every chip-select frame, returns pat() bytes
  logic [7:0] fr [128][72];
  int         flen [128];
  int         nfr = 0;
  int         bitc = 0;
  logic [7:0] sh = '0;
  logic       cs_p = 1'b1, sck_p = 1'b0;

  always @(negedge clk) begin
    logic [7:0] p;
    if (cs_p && !spi_cs_n) begin
      bitc = 0; p = pat(0); miso_q = p[7];
    end else if (!spi_cs_n && sck_p && !spi_sck) begin
      p = pat(bitc / 8); miso_q = p[7 - (bitc % 8)];
    end
    if (!spi_cs_n && !sck_p && spi_sck) begin
      sh = {sh[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0 && nfr < 128 && bitc / 8 <= 72) fr[nfr][bitc/8 - 1] = sh;
    end
    if (!cs_p && spi_cs_n) begin
      if (nfr < 128) flen[nfr] = bitc / 8;
      nfr++;
    end
    cs_p  = spi_cs_n;
    sck_p = spi_sck;
  end

  // bench model of programmed state
  logic [7:0]  menu_m [8];
  logic [1:0]  typ_m [8];
  logic [7:0]  pre0_m, pre1_m;
  logic [23:0] faddr_m;
  logic [7:0]  bbuf [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] v);
    for (int t = 0; t < 5000; t++) begin
      rd(0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic program_regs();
    logic [31:0] pt;
    wr(2, {menu_m[3], menu_m[2], menu_m[1], menu_m[0]});
    wr(3, {menu_m[7], menu_m[6], menu_m[5], menu_m[4]});
    pt = {16'h0, pre1_m, pre0_m};
    for (int i = 0; i < 8; i++) pt[16 + 2*i +: 2] = typ_m[i];
    wr(4, pt);
    wr(1, {8'h00, faddr_m});
  endtask

  task automatic fill_buf();
    for (int w = 0; w < 16; w++)
      wr(16 + w, {bbuf[4*w+3], bbuf[4*w+2], bbuf[4*w+1], bbuf[4*w]});
  endtask

  task automatic check_buf();
    logic [31:0] v;
    for (int w = 0; w < 16; w++) begin
      rd(16 + w, v);
      for (int j = 0; j < 4; j++) chk("R5 buffer byte", 32'(v[8*j +: 8]), 32'(bbuf[4*w+j]));
    end
  endtask

  task automatic run_txn(input int idx, input bit atom, input bit psel, input bit den, input int cnt);
    logic [31:0] v;
    logic [1:0]  ty;
    int base, m, hdr, ndat;
    ty = typ_m[idx];
    base = nfr;
    wr(0, (32'(den) << 22) | (32'(cnt) << 16) | (32'(idx) << 12) |
          (32'(psel) << 11) | (32'(atom) << 10) | (32'd1 << 9));
    rd(0, v);
    if (atom && !ty[0]) begin
      chk("R8 access error set", 32'(v[4]), 1);
      chk("R8 busy stays clear", 32'(v[0]), 0);
      repeat (40) @(negedge clk);
      chk("R8 no frame", 32'(nfr - base), 0);
      wr(0, 32'h10);
      rd(0, v);
      chk("R11 access error cleared", 32'(v[4]), 0);
      return;
    end
    chk("R9 busy after go", 32'(v[0]), 1);
    wait_idle(v);
    chk("R9 done at finish", 32'(v[2]), 1);
    chk("R9 cs released", 32'(spi_cs_n), 1);
    chk("R7 frame count", 32'(nfr - base), atom ? 2 : 1);
    if (atom) begin
      chk("R7 prefix frame length", 32'(flen[base]), 1);
      chk("R7 prefix byte", 32'(fr[base][0]), 32'(psel ? pre1_m : pre0_m));
    end
    m    = base + (atom ? 1 : 0);
    hdr  = ty[1] ? 4 : 1;
    ndat = den ? cnt + 1 : 0;
    chk("R2 R12 opcode byte", 32'(fr[m][0]), 32'(menu_m[idx]));
    if (ty[1])
      for (int k = 0; k < 3; k++)
        chk("R3 address byte", 32'(fr[m][1+k]), 32'(faddr_m[23 - 8*k -: 8]));
    chk(den ? "R3 R4 R5 frame length" : "R6 frame length", 32'(flen[m]), 32'(hdr + ndat));
    for (int i = 0; i < ndat; i++) begin
      if (ty[0]) chk("R4 write data byte", 32'(fr[m][hdr+i]), 32'(bbuf[i]));
      else       bbuf[i] = pat(hdr + i);
    end
    if (!ty[0] && den) check_buf();
    wr(0, 32'h4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rd(0, v);
    chk("R1 csw reset", v, 0);
    chk("R1 cs high", 32'(spi_cs_n), 1);
    chk("R1 sck low", 32'(spi_sck), 0);
    rst_n = 1'b1;
    rd(0, v);
    chk("R1 csw after release", v, 0);

    menu_m = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h17, 8'h28};
    typ_m  = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd2, 2'd1, 2'd0};
    pre0_m = 8'h5A; pre1_m = 8'hC3; faddr_m = 24'h12_34_56;
    for (int i = 0; i < 64; i++) bbuf[i] = 8'(i * 7 + 3);
    program_regs();
    fill_buf();

    run_txn(0, 1, 1, 1, 63);   // R4 full buffer, R7 prefix 1
    run_txn(3, 1, 0, 1, 2);    // R7 prefix 0, write without address
    run_txn(2, 0, 0, 1, 15);   // R5 read with address
    run_txn(1, 0, 0, 0, 63);   // R6 data off, count ignored
    run_txn(5, 1, 0, 1, 4);    // R8 atomic on read entry
    run_txn(7, 0, 0, 1, 0);    // R5 single byte read, no address

    // R10: go while busy
    base = nfr;
    wr(0, (32'd1 << 22) | (32'd63 << 16) | (32'd0 << 12) | (32'd1 << 9));
    wr(0, (32'd1 << 12) | (32'd1 << 9));
    rd(0, v);
    chk("R10 cycle error set", 32'(v[3]), 1);
    chk("R10 still busy", 32'(v[0]), 1);
    chk("R10 index kept", 32'(v[14:12]), 0);
    wait_idle(v);
    chk("R10 one frame", 32'(nfr - base), 1);
    chk("R10 frame unchanged", 32'(flen[base]), 68);
    chk("R10 opcode unchanged", 32'(fr[base][0]), 32'(menu_m[0]));

    // R11: write-1-to-clear
    wr(0, 32'h0);
    rd(0, v);
    chk("R11 cycle error kept on 0", 32'(v[3]), 1);
    chk("R11 done kept on 0", 32'(v[2]), 1);
    wr(0, 32'h8);
    rd(0, v);
    chk("R11 cycle error cleared", 32'(v[3]), 0);
    chk("R11 done untouched", 32'(v[2]), 1);
    wr(0, 32'h4);
    rd(0, v);
    chk("R11 done cleared", 32'(v[2]), 0);

    // constrained random commands
    for (int it = 0; it < 30; it++) begin
      int cnt;
      if (it % 5 == 0) begin
        for (int i = 0; i < 8; i++) begin
          menu_m[i] = 8'($urandom);
          typ_m[i]  = 2'($urandom);
        end
        pre0_m = 8'($urandom); pre1_m = 8'($urandom);
      end
      faddr_m = 24'($urandom);
      for (int i = 0; i < 64; i++) bbuf[i] = 8'($urandom);
      program_regs();
      fill_buf();
      cnt = ($urandom_range(0, 7) == 0) ? 63 : int'($urandom_range(0, 12));
      run_txn(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
              1'($urandom_range(0, 3) != 0), cnt);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule